// File: doc/BRIEF.md
# Daisy-Chained Interrupt Requester

This block is the interrupting side of a backplane slot whose interrupt acknowledge is passed from slot to slot along a daisy chain. Local logic pulses a raise input. The block then holds a pending request and pulls one of seven active-low request lines low. The line is picked by a configured level from 1 to 7, where 7 is the most urgent. A configured level of 0 turns the unit off.

When a handler starts an acknowledge cycle, it drives the global acknowledge low, places the level it is serving on three address lines, and feeds the chain into this slot's chain input. The unit answers if the level matches and a request is pending. In that case it keeps the chain closed and does not forward the acknowledge. It drives its status word, and one clock later it strobes the data-acknowledge line. If the unit does not answer, it passes the chain acknowledge to its downstream output. The data lines, the strobe and the request are all released once the global acknowledge goes high again. Because an answering unit never forwards, the slot nearest the handler wins among units that share a line.

The status word carries the logical address in bits 7..0, a cause code in bits 15..8 and device-specific bits in 31..16. A parameter sets the width to 8, 16 or 32 bits. Every backplane input goes through a two-flop synchronizer.

Top module: `irq_chain_node`

## Requirements
- R1: After reset all request pulls are low, the chain output and the data-acknowledge are high, and no data line is enabled.
- R2: One clock after a raise pulse, with the configured level L from 1 to 7, exactly pull bit L-1 is high (bit k serves level k+1). With L = 0 no pull bit is ever set. At most one pull bit is high at any time.
- R3: The unit answers when the global acknowledge and the chain input are both low, the address equals L, and a request is pending. The data enables and the status word appear at the third clock edge after those inputs change.
- R4: The data-acknowledge goes low exactly one clock after the status word is first driven, and only while that word is still driven.
- R5: If the address does not match L, or no request is pending, the chain output goes low at the third clock edge after the chain input falls, and no data line is enabled.
- R6: The chain output and the data enables are never active together. An answering unit keeps the chain output high for the whole cycle.
- R7: A forwarding unit raises its chain output at the third clock edge after the chain input rises, and not earlier.
- R8: At the third clock edge after the global acknowledge rises, an answering unit releases its data enables and the data-acknowledge, and clears its request pull.
- R9: In the status word, bits 7..0 hold the logical address, bits 15..8 the cause code and bits 31..16 the device bits. Only the low SW bits (SW = 8, 16 or 32) are enabled. Lines above SW are neither enabled nor driven high.
- R10: A change on a backplane input has no visible effect at the second clock edge after the change.
- R11: Once the unit is forwarding in a cycle, a request raised during that cycle does not turn it into an answerer. It answers in the next cycle instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_level | input | 3 | Request level, 1..7; 0 disables |
| cfg_laddr | input | 8 | Logical address, status bits 7..0 |
| cfg_cause | input | 8 | Cause code, status bits 15..8 |
| cfg_dev | input | 16 | Device bits, status bits 31..16 |
| raise_req | input | 1 | One-cycle pulse that raises a request |
| iack_n | input | 1 | Global acknowledge, active low |
| iackin_n | input | 1 | Chain acknowledge from upstream, active low |
| lvl_addr | input | 3 | Level being acknowledged |
| irq_pull | output | 7 | Pull-low enables, bit k = level k+1 |
| iackout_n | output | 1 | Chain acknowledge to downstream, active low |
| dtack_n | output | 1 | Data-acknowledge strobe, active low |
| data_o | output | 32 | Status word value |
| data_oe | output | 32 | Per-bit drive enables |

## Verification
The hardest case to reach is a request that becomes pending while the unit is already forwarding an acknowledge for its own level. To get there, the bench opens a cycle with no request pending and waits until the chain output is low. It then pulses raise mid-cycle, checks that the unit keeps forwarding, and closes the cycle. A fresh cycle must then be answered. The vector table covers the other cases: matched and unmatched levels, the disabled level 0, and cycles with no request pending.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FWD   = 2'd1,
        ST_DRIVE = 2'd2,
        ST_ACK   = 2'd3
    } node_st_e;

    typedef struct packed {
        node_st_e st;
        logic     pend;
    } node_regs_t;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int              W       = 1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/irq_level_drv.sv
module irq_level_drv #(
    parameter int NLVL = 7,
    parameter int LW   = 3
) (
    input  logic            en,
    input  logic [LW-1:0]   level,
    output logic [NLVL-1:0] pull
);
    for (genvar k = 0; k < NLVL; k++) begin : g_line
        localparam logic [LW-1:0] CODE = LW'(k + 1);
        assign pull[k] = en && (level == CODE);
    end
endmodule

// File: rtl/irq_status_fmt.sv
module irq_status_fmt #(
    parameter int SW = 16,
    parameter int DW = 32
) (
    input  logic          drive,
    input  logic [7:0]    laddr,
    input  logic [7:0]    cause,
    input  logic [DW-17:0] dev,
    output logic [DW-1:0] data,
    output logic [DW-1:0] oe
);
    logic [DW-1:0] full;
    assign full = {dev, cause, laddr};

    for (genvar i = 0; i < DW; i++) begin : g_bit
        localparam logic LIVE = (i < SW);
        assign oe[i]   = drive & LIVE;
        assign data[i] = drive & LIVE & full[i];
    end
endmodule

// File: rtl/irq_chain_node.sv
module irq_chain_node
    import irq_chain_pkg::*;
#(
    parameter int SW   = 16,
    parameter int NLVL = 7,
    parameter int LW   = 3,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LW-1:0]   cfg_level,
    input  logic [7:0]      cfg_laddr,
    input  logic [7:0]      cfg_cause,
    input  logic [DW-17:0]  cfg_dev,
    input  logic            raise_req,
    input  logic            iack_n,
    input  logic            iackin_n,
    input  logic [LW-1:0]   lvl_addr,
    output logic [NLVL-1:0] irq_pull,
    output logic            iackout_n,
    output logic            dtack_n,
    output logic [DW-1:0]   data_o,
    output logic [DW-1:0]   data_oe
);
    localparam int             SYW      = LW + 2;
    localparam logic [SYW-1:0] SYNC_RST = {2'b11, {LW{1'b0}}};

    logic [SYW-1:0] sy_raw;
    logic [SYW-1:0] sy_out;
    logic           iack_s;
    logic           iackin_s;
    logic [LW-1:0]  addr_s;

    assign sy_raw = {iack_n, iackin_n, lvl_addr};

    irq_sync #(.W(SYW), .RST_VAL(SYNC_RST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sy_raw),
        .sync_o  (sy_out)
    );

    assign iack_s   = sy_out[SYW-1];
    assign iackin_s = sy_out[SYW-2];
    assign addr_s   = sy_out[LW-1:0];

    node_regs_t r_d, r_q;
    logic       lvl_ok;
    logic       hit;
    logic       drive;

    always_comb begin
        r_d    = r_q;
        lvl_ok = (cfg_level != '0);
        hit    = !iackin_s && !iack_s && r_q.pend && (addr_s == cfg_level);
        if (raise_req && lvl_ok) begin
            r_d.pend = 1'b1;
        end
        case (r_q.st)
            ST_IDLE: begin
                if (hit) begin
                    r_d.st = ST_DRIVE;
                end else if (!iackin_s) begin
                    r_d.st = ST_FWD;
                end
            end
            ST_FWD: begin
                if (iackin_s) begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_DRIVE, ST_ACK: begin
                if (iack_s) begin
                    r_d.st   = ST_IDLE;
                    r_d.pend = raise_req && lvl_ok;
                end else begin
                    r_d.st = ST_ACK;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.pend <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign drive     = (r_q.st == ST_DRIVE) || (r_q.st == ST_ACK);
    assign iackout_n = (r_q.st != ST_FWD);
    assign dtack_n   = (r_q.st != ST_ACK);

    irq_level_drv #(.NLVL(NLVL), .LW(LW)) u_lvl (
        .en    (r_q.pend),
        .level (cfg_level),
        .pull  (irq_pull)
    );

    irq_status_fmt #(.SW(SW), .DW(DW)) u_fmt (
        .drive (drive),
        .laddr (cfg_laddr),
        .cause (cfg_cause),
        .dev   (cfg_dev),
        .data  (data_o),
        .oe    (data_oe)
    );

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_pull)); // R2

    AST_ANS_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_oe[0]) |-> $past(r_q.pend)); // R3

    AST_STROBE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n) |-> ($past(data_oe[0]) && data_oe[0])); // R4

    AST_ONE_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!iackout_n && data_oe[0])); // R6

    AST_FWD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!iackout_n && iackin_s) |=> iackout_n); // R7

    AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && iack_s) |=> (dtack_n && (data_oe == '0))); // R8

    AST_UPPER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (SW < DW) |-> (data_oe[DW-1] == 1'b0)); // R9
endmodule

// File: tb/irq_chain_node_test.sv
module irq_chain_node_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_level = 3'd0;
    logic [7:0]  cfg_laddr = 8'h3C;
    logic [7:0]  cfg_cause = 8'hFD;
    logic [15:0] cfg_dev = 16'hA5A5;
    logic        raise_req = 1'b0;
    logic        iack_n = 1'b1;
    logic        iackin_n = 1'b1;
    logic [2:0]  lvl_addr = 3'd0;
    logic [6:0]  irq_pull;
    logic        iackout_n;
    logic        dtack_n;
    logic [31:0] data_o;
    logic [31:0] data_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    localparam logic [31:0] EXP_WORD = 32'h0000FD3C;
    localparam logic [31:0] EXP_OE   = 32'h0000FFFF;

    // entry: {level[7:5], addr[4:2], raise[1], answers[0]}
    localparam int NV = 9;
    localparam logic [7:0] VEC [NV] = '{
        {3'd5, 3'd5, 1'b1, 1'b1},
        {3'd5, 3'd3, 1'b1, 1'b0},
        {3'd7, 3'd7, 1'b1, 1'b1},
        {3'd1, 3'd1, 1'b1, 1'b1},
        {3'd1, 3'd2, 1'b1, 1'b0},
        {3'd3, 3'd3, 1'b0, 1'b0},
        {3'd0, 3'd0, 1'b1, 1'b0},
        {3'd6, 3'd6, 1'b1, 1'b1},
        {3'd4, 3'd7, 1'b1, 1'b0}
    };

    irq_chain_node uut (
        .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .cfg_laddr(cfg_laddr),
        .cfg_cause(cfg_cause), .cfg_dev(cfg_dev), .raise_req(raise_req),
        .iack_n(iack_n), .iackin_n(iackin_n), .lvl_addr(lvl_addr),
        .irq_pull(irq_pull), .iackout_n(iackout_n), .dtack_n(dtack_n),
        .data_o(data_o), .data_oe(data_oe)
    );

    always #10 clk = ~clk;

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; raise_req = 1'b0; iack_n = 1'b1; iackin_n = 1'b1; lvl_addr = 3'd0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic pulse_raise();
        raise_req = 1'b1;
        step(1);
        raise_req = 1'b0;
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 pull", 32'(irq_pull), 32'h0);
        chk("R1 iackout", 32'(iackout_n), 32'h1);
        chk("R1 dtack", 32'(dtack_n), 32'h1);
        chk("R1 oe", data_oe, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [2:0] lv, ad;
            logic rs, an;
            logic [6:0] ep;
            {lv, ad, rs, an} = VEC[i];
            ep = (lv != 3'd0 && rs) ? 7'(1 << (int'(lv) - 1)) : 7'd0;
            do_reset();
            cfg_level = lv;
            if (rs) pulse_raise();
            chk("R2 pull", 32'(irq_pull), 32'(ep));
            lvl_addr = ad; iack_n = 1'b0; iackin_n = 1'b0;
            step(2);
            chk("R10 chain out unchanged", 32'(iackout_n), 32'h1);
            chk("R10 oe unchanged", data_oe, 32'h0);
            step(1);
            if (an) begin
                chk("R3 oe", data_oe, EXP_OE);
                chk("R9 word", data_o, EXP_WORD);
                chk("R6 chain closed", 32'(iackout_n), 32'h1);
                chk("R4 strobe not yet", 32'(dtack_n), 32'h1);
                step(1);
                chk("R4 strobe", 32'(dtack_n), 32'h0);
                chk("R6 chain closed late", 32'(iackout_n), 32'h1);
            end else begin
                chk("R5 forward", 32'(iackout_n), 32'h0);
                chk("R5 no drive", data_oe, 32'h0);
            end
            iack_n = 1'b1; iackin_n = 1'b1;
            step(2);
            if (!an) chk("R7 still forwarding", 32'(iackout_n), 32'h0);
            step(1);
            chk("R7 chain out released", 32'(iackout_n), 32'h1);
            chk("R8 strobe released", 32'(dtack_n), 32'h1);
            chk("R8 oe released", data_oe, 32'h0);
            chk("R8 pull after cycle", 32'(irq_pull), an ? 32'h0 : 32'(ep));
        end

        // R11: request raised while already forwarding on own level
        do_reset();
        cfg_level = 3'd2;
        lvl_addr = 3'd2; iack_n = 1'b0; iackin_n = 1'b0;
        step(3);
        chk("R11 forwarding", 32'(iackout_n), 32'h0);
        pulse_raise();
        step(3);
        chk("R11 still forwarding", 32'(iackout_n), 32'h0);
        chk("R11 no drive", data_oe, 32'h0);
        chk("R11 pending", 32'(irq_pull), 32'h2);
        iack_n = 1'b1; iackin_n = 1'b1;
        step(4);
        iack_n = 1'b0; iackin_n = 1'b0;
        step(3);
        chk("R11 answers next cycle", data_oe, EXP_OE);
        chk("R3 word next cycle", data_o, EXP_WORD);
        iack_n = 1'b1; iackin_n = 1'b1;
        step(3);
        chk("R8 pull cleared", 32'(irq_pull), 32'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule